// File: doc/BRIEF.md
# Binned Column Pair Summer and Level Normalizer

This block sits in the pixel output path of an image sensor. It receives column conversion codes in horizontal scan order, one per valid cycle. In binning mode each of these codes is already the sum of two vertically neighbouring pixels of one color. The block adds each code to the code two columns further along, which in a Bayer mosaic is the nearest pixel of the same color. It then divides the four-pixel total by four, so that binned output has the same signal level as full-resolution output.

In full-resolution mode every code goes straight through with one cycle of latency. It is only clamped to the output width. A line-start flag sent with the first code of each line does two things: it resets the color tracking to column zero, and it samples the mode request. Because of this, a mode change can only take effect on a line boundary. Each output also carries a color bit, which gives the column parity of the pixels it came from.

Top module: `hbin_norm`

## Requirements
- R1: While reset is high and in the cycle after it, out_valid is 0 and out_code is 0.
- R2: In full mode, a valid input code of at most 4095 appears unchanged on out_code, with out_valid high, in the cycle after it is presented.
- R3: In full mode, an input code above 4095 is output as 4095.
- R4: In binning mode, columns are numbered 0 to 3 within each group of four, counted from the line-start sample. The output produced with column 2 is (c0+c2)>>2 and the output produced with column 3 is (c1+c3)>>2, truncated.
- R5: In binning mode, columns 0 and 1 of a group produce no output, so four inputs give exactly two outputs.
- R6: out_color is 0 for outputs derived from even columns (0 and 2) and 1 for outputs derived from odd columns (1 and 3), in both modes.
- R7: A sample with in_first high is column 0. Any incomplete group left from the previous line is dropped.
- R8: The mode (in_bin: 0 = full, 1 = binning) is sampled only together with a line-start sample. A change in the middle of a line has no effect until the next line start.
- R9: Cycles with in_valid low do not advance the column position and produce no output.
- R10: In binning mode, two maximum codes (8191) sum to 4095 with no wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input code is valid this cycle |
| in_first | input | 1 | Marks the first column of a line |
| in_bin | input | 1 | Mode request, 1 = 2x2 binning, 0 = full resolution; sampled at line start |
| in_code | input | 13 | Column conversion code |
| out_valid | output | 1 | Output code is valid |
| out_code | output | 12 | Normalized or passed-through code |
| out_color | output | 1 | Column parity of the output's source pixels |

## Verification
The hardest cases to reach are those where the column position and the stored partial sums disagree with what a naive scan would expect. Examples are a line that ends part-way through a group, a mode request that toggles in the middle of a line, and idle gaps between samples. The stimulus covers these with short directed lines. It starts a fresh line right after two columns, so a stale position would produce an output too early. It flips in_bin between line starts and mid-line. It also inserts idle cycles between the samples of one group, and each of these situations has a known expected pair sum.

// File: rtl/hbin_pkg.sv
package hbin_pkg;
  typedef enum logic {
    MODE_FULL = 1'b0,
    MODE_BIN  = 1'b1
  } bin_mode_e;

  localparam int GROUP_COLS = 4;
  localparam int POS_W      = $clog2(GROUP_COLS);
  localparam int NORM_SHIFT = 2;
endpackage

// File: rtl/hbin_phase_track.sv
module hbin_phase_track
  import hbin_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_first,
  input  logic             mode_req,
  output logic [POS_W-1:0] col_pos,
  output bin_mode_e        mode_cur
);
  logic [POS_W-1:0] pos_q;
  bin_mode_e        mode_q;

  // a line-start sample is column 0 and carries the mode for the line
  assign col_pos  = in_first ? '0 : pos_q;
  assign mode_cur = in_first ? bin_mode_e'(mode_req) : mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q  <= '0;
      mode_q <= MODE_FULL;
    end else if (in_valid) begin
      pos_q <= col_pos + POS_W'(1);
      if (in_first) mode_q <= bin_mode_e'(mode_req);
    end
  end

  AST_MODE_STICKY: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_first) |=> $stable(mode_q)); // R8
  AST_POS_STALL: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(pos_q)); // R9
endmodule

// File: rtl/hbin_pair_sum.sv
module hbin_pair_sum
  import hbin_pkg::*;
#(
  parameter int IN_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_code,
  input  logic [POS_W-1:0] col_pos,
  input  bin_mode_e        mode_cur,
  output logic             emit,
  output logic [IN_W:0]    norm_val,
  output logic             color
);
  localparam int LANES = GROUP_COLS / 2;
  localparam int LANE_W = $clog2(LANES);

  logic [IN_W-1:0] hold_q [LANES];
  logic [IN_W:0]   pair_sum;
  logic [LANE_W-1:0] lane;
  logic            second_half;

  assign lane        = col_pos[LANE_W-1:0];
  assign second_half = col_pos[POS_W-1];

  // one holding register per color lane, filled by the first half of a group
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)
        hold_q[g] <= '0;
      else if (in_valid && !second_half && lane == LANE_W'(g))
        hold_q[g] <= in_code;
    end
  end

  assign pair_sum = {1'b0, hold_q[lane]} + {1'b0, in_code};

  always_comb begin
    if (mode_cur == MODE_BIN) begin
      emit     = in_valid && second_half;
      norm_val = pair_sum >> NORM_SHIFT;
    end else begin
      emit     = in_valid;
      norm_val = {1'b0, in_code};
    end
  end

  assign color = col_pos[0];

  AST_BIN_FIRST_HALF_QUIET: assert property (@(posedge clk) disable iff (rst)
    (mode_cur == MODE_BIN && !second_half) |-> !emit); // R5
endmodule

// File: rtl/hbin_sat_reg.sv
module hbin_sat_reg #(
  parameter int IN_W  = 13,
  parameter int OUT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             emit,
  input  logic [IN_W:0]    norm_val,
  input  logic             color,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_code,
  output logic             out_color
);
  localparam logic [IN_W:0] LIMIT = (IN_W+1)'((64'd1 << OUT_W) - 64'd1);

  logic [OUT_W-1:0] sat_val;

  assign sat_val = (norm_val > LIMIT) ? '1 : norm_val[OUT_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_code  <= '0;
      out_color <= 1'b0;
    end else begin
      out_valid <= emit;
      if (emit) begin
        out_code  <= sat_val;
        out_color <= color;
      end
    end
  end

  AST_SAT_CEILING: assert property (@(posedge clk) disable iff (rst)
    (emit && norm_val > LIMIT) |=> (out_code == {OUT_W{1'b1}})); // R3
endmodule

// File: rtl/hbin_norm.sv
module hbin_norm
  import hbin_pkg::*;
#(
  parameter int IN_W  = 13,
  parameter int OUT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_first,
  input  logic             in_bin,
  input  logic [IN_W-1:0]  in_code,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_code,
  output logic             out_color
);
  logic [POS_W-1:0] col_pos;
  bin_mode_e        mode_cur;
  logic             emit;
  logic [IN_W:0]    norm_val;
  logic             color;

  hbin_phase_track u_track (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_first (in_first),
    .mode_req (in_bin),
    .col_pos  (col_pos),
    .mode_cur (mode_cur)
  );

  hbin_pair_sum #(.IN_W(IN_W)) u_sum (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_code  (in_code),
    .col_pos  (col_pos),
    .mode_cur (mode_cur),
    .emit     (emit),
    .norm_val (norm_val),
    .color    (color)
  );

  hbin_sat_reg #(.IN_W(IN_W), .OUT_W(OUT_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .emit      (emit),
    .norm_val  (norm_val),
    .color     (color),
    .out_valid (out_valid),
    .out_code  (out_code),
    .out_color (out_color)
  );

  AST_FULL_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode_cur == MODE_FULL) |=> (out_valid && out_color == $past(col_pos[0]))); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R9
  AST_BIN_SECOND_HALF_EMITS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode_cur == MODE_BIN && col_pos[POS_W-1]) |=> out_valid); // R4
endmodule

// File: tb/tb_hbin_norm.sv
module tb_hbin_norm;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_first = 1'b0;
  logic        in_bin = 1'b0;
  logic [12:0] in_code = '0;
  logic        out_valid;
  logic [11:0] out_code;
  logic        out_color;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  hbin_norm dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_first(in_first),
    .in_bin(in_bin), .in_code(in_code), .out_valid(out_valid),
    .out_code(out_code), .out_color(out_color)
  );

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s got %0d expected %0d", req, got, exp);
    end
  endtask

  // present one cycle of input; return 1 ns after the capturing edge
  task automatic step(input logic v, input logic f, input logic m, input int c);
    in_valid = v; in_first = f; in_bin = m; in_code = 13'(c);
    @(posedge clk); #1;
    in_valid = 1'b0; in_first = 1'b0;
  endtask

  task automatic expect_out(input string req, input int code, input int col);
    chk({req, " valid"}, int'(out_valid), 1);
    chk({req, " code"}, int'(out_code), code);
    chk({req, " color"}, int'(out_color), col);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 valid in reset", int'(out_valid), 0);
    rst = 1'b0;
    @(posedge clk); #1;
    chk("R1 valid after reset", int'(out_valid), 0);
    chk("R1 code after reset", int'(out_code), 0);
  endtask

  task automatic t_full_pass();
    step(1, 1, 0, 123);  expect_out("R2 R6 full col0", 123, 0);
    step(1, 0, 0, 4095); expect_out("R2 R6 full col1", 4095, 1);
    step(1, 0, 0, 0);    expect_out("R2 full zero", 0, 0);
  endtask

  task automatic t_full_clamp();
    step(1, 0, 0, 5000); expect_out("R3 clamp 5000", 4095, 1);
    step(1, 0, 0, 8191); expect_out("R3 clamp 8191", 4095, 0);
  endtask

  task automatic t_bin_group();
    step(1, 1, 1, 100); chk("R5 bin col0 quiet", int'(out_valid), 0);
    step(1, 0, 1, 200); chk("R5 bin col1 quiet", int'(out_valid), 0);
    step(1, 0, 1, 300); expect_out("R4 R6 even pair", 100, 0);
    step(1, 0, 1, 401); expect_out("R4 R6 odd pair", 150, 1);
    step(1, 0, 1, 7);   chk("R5 group2 col0 quiet", int'(out_valid), 0);
    step(1, 0, 1, 9);   chk("R5 group2 col1 quiet", int'(out_valid), 0);
    step(1, 0, 1, 10);  expect_out("R4 truncate even", 4, 0);
    step(1, 0, 1, 12);  expect_out("R4 truncate odd", 5, 1);
  endtask

  task automatic t_gaps();
    step(1, 1, 1, 40);  chk("R5 gap col0", int'(out_valid), 0);
    step(0, 0, 1, 999); chk("R9 idle 1", int'(out_valid), 0);
    step(1, 0, 1, 60);  chk("R9 col1 after gap", int'(out_valid), 0);
    step(0, 0, 1, 999); chk("R9 idle 2", int'(out_valid), 0);
    step(1, 0, 1, 80);  expect_out("R9 R4 even after gaps", 30, 0);
    step(0, 0, 1, 999); chk("R9 idle 3", int'(out_valid), 0);
    step(1, 0, 1, 100); expect_out("R9 R4 odd after gaps", 40, 1);
  endtask

  task automatic t_partial_line();
    step(1, 1, 1, 1000);
    step(1, 0, 1, 2000);
    step(1, 1, 1, 8);  chk("R7 restart col0 quiet", int'(out_valid), 0);
    step(1, 0, 1, 12); chk("R7 restart col1 quiet", int'(out_valid), 0);
    step(1, 0, 1, 24); expect_out("R7 fresh even pair", 8, 0);
  endtask

  task automatic t_mode_midline();
    step(1, 1, 1, 16); chk("R8 bin line col0", int'(out_valid), 0);
    step(1, 0, 0, 20); chk("R8 midline full ignored", int'(out_valid), 0);
    step(1, 0, 0, 24); expect_out("R8 still binning even", 10, 0);
    step(1, 0, 0, 28); expect_out("R8 still binning odd", 12, 1);
    step(1, 1, 0, 50); expect_out("R8 full at line start", 50, 0);
    step(1, 0, 1, 60); expect_out("R8 midline bin ignored", 60, 1);
  endtask

  task automatic t_bin_max();
    step(1, 1, 1, 8191);
    step(1, 0, 1, 8191);
    step(1, 0, 1, 8191); expect_out("R10 max even", 4095, 0);
    step(1, 0, 1, 8191); expect_out("R10 max odd", 4095, 1);
  endtask

  initial begin
    t_reset();
    t_full_pass();
    t_full_clamp();
    t_bin_group();
    t_gaps();
    t_partial_line();
    t_mode_midline();
    t_bin_max();
    step(0, 0, 0, 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired got 0 expected 1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule